// File: doc/BRIEF.md
# Nine-bit UART receiver with expansion-bit comparison

This block is the receive half of a UART that carries frames of eight data bits, sent least significant bit first, with an optional ninth expansion bit and an optional parity bit after them. It oversamples the serial line on a baud tick that runs at sixteen times the bit rate. It confirms each start bit at its midpoint, assembles the frame, checks parity and the stop bit, and writes the byte to a receive data register.

When comparison mode is active, the received expansion bit is compared with a programmable detection level. A frame whose expansion bit equals the level is reported on the reception-status interrupt and sets a sticky detect flag. A frame whose expansion bit differs is reported on the success interrupt. Any parity, framing or overrun error sends the frame to the status interrupt and sets the matching sticky flag. Software reads the byte by pulsing a data-read strobe, and clears flags one at a time with a write-one-to-clear strobe.

Top module: `xbit_uart_rx`

## Requirements
- R1: Comparison mode is active only when `xb_enable`=1, `cmp_disable`=0 and `data_cmp_enable`=0. Outside that mode the detect flag (bit 3) never sets, and a frame with no error raises `irq_ok`.
- R2: A frame is: a start bit (low), data bits 0..7 LSB first, then the expansion bit if `xb_enable`=1, then the parity bit if `parity_en`=1, then a stop bit. Each bit lasts 16 baud ticks.
- R3: In comparison mode, a frame with no error whose expansion bit equals `detect_level` raises `irq_status` and sets `status_flags[3]`.
- R4: In comparison mode, a frame with no error whose expansion bit differs from `detect_level` raises `irq_ok` and leaves the flags unchanged.
- R5: Each completed frame raises exactly one of `irq_status` and `irq_ok`, for one cycle, in the same cycle that `rx_data` and the flags take the frame's result.
- R6: A frame that completes while the previous byte is still unread (no `rd_strobe` since it was stored) sets `status_flags[2]` (overrun), raises `irq_status`, and leaves `rx_data` unchanged. Otherwise the byte is stored in `rx_data`.
- R7: With `parity_en`=1, the ones in the data bits, the expansion bit (when enabled) and the parity bit must total even (`parity_odd`=0) or odd (`parity_odd`=1). On a mismatch `status_flags[0]` sets, `irq_status` rises and `irq_ok` does not.
- R8: A stop bit sampled low sets `status_flags[1]` (framing) and raises `irq_status`.
- R9: A frame whose expansion bit matches and which has an overrun also sets `status_flags[3]`. A matching frame whose only errors are parity or framing does not set it.
- R10: The flags are sticky. A 1 on `clr_flags[i]` clears `status_flags[i]`. Bit 0 is parity, bit 1 framing, bit 2 overrun, bit 3 expansion detect.
- R11: After reset, `status_flags`=0, `rx_data`=0, and both interrupts are low.
- R12: A low pulse on the line shorter than half a bit is not taken as a start bit. It raises no interrupt and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| xb_enable | input | 1 | Frame carries an expansion bit |
| cmp_disable | input | 1 | Turns off expansion-bit comparison |
| data_cmp_enable | input | 1 | Data-comparison variant selected (turns off this comparison) |
| detect_level | input | 1 | Expansion-bit level that counts as a match |
| parity_en | input | 1 | Frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Marks the received byte as read |
| clr_flags | input | 4 | Write-one-to-clear strobes for the flags |
| rx_data | output | 8 | Receive data register |
| status_flags | output | 4 | Sticky flags: parity, framing, overrun, detect |
| irq_status | output | 1 | Reception-status interrupt pulse |
| irq_ok | output | 1 | Successful-reception interrupt pulse |

## Verification
A wrong bit counter or a sampling point off by one tick shows up as a byte in `rx_data` that is shifted or has a wrong bit. It may also show as a false framing or parity flag, in the same cycle as that frame's interrupt. A stale unread-byte state shows as an overrun flag, or a missing one, on the next frame, one frame period later. A wrong comparison decision sends the interrupt to the other output. Random frames are mixed with directed cases: overrun on a matching frame, a short glitch, and every mode in which comparison is off. Each frame's interrupt, data and flags are compared with a model in the bench.

// File: rtl/xbr_pkg.sv
// Shared types for the nine-bit UART receiver.
// Assumes: fixed 8-bit data field; extra frame bits are described by flags.
package xbr_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 4;

    // Flag positions inside status_flags
    localparam int FL_PAR = 0;
    localparam int FL_FRM = 1;
    localparam int FL_OVR = 2;
    localparam int FL_XDT = 3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              xbit;
        logic              par_bit;
        logic              xb_used;
        logic              par_used;
        logic              stop_ok;
    } frame_t;

    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic match;
    } verdict_t;
endpackage

// File: rtl/xbr_bit_engine.sv
// Serial front end: synchronises the line, finds and confirms start bits,
// samples each bit at its centre and emits one frame record per frame.
// Assumes: baud_tick pulses OSR times per bit; xb_en and par_en are
// stable from the start bit to the stop bit of a frame.
module xbr_bit_engine
    import xbr_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rx_line,
    input  logic   baud_tick,
    input  logic   xb_en,
    input  logic   par_en,
    output logic   frame_done,
    output frame_t frame_q
);
    localparam int CNT_W = $clog2(OSR);
    localparam int MID   = OSR / 2 - 1;
    localparam int PAY_W = DATA_W + 2;
    localparam int IDX_W = $clog2(PAY_W + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    rx_state_t              state;
    logic [CNT_W-1:0]       tick_cnt;
    logic [IDX_W-1:0]       bit_idx;
    logic [IDX_W-1:0]       last_idx;
    logic [PAY_W-1:0]       pay;
    logic                   xb_l;
    logic                   par_l;

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
    end
    assign line_s = sync_q[SYNC_STAGES-1];

    // Frame state machine: start check, bit sampling, stop sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            tick_cnt   <= '0;
            bit_idx    <= '0;
            last_idx   <= '0;
            pay        <= '0;
            xb_l       <= 1'b0;
            par_l      <= 1'b0;
            frame_done <= 1'b0;
            frame_q    <= '0;
        end else begin
            frame_done <= 1'b0;
            if (baud_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line_s) begin
                            state    <= RX_START;
                            tick_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick_cnt == CNT_W'(MID)) begin
                            tick_cnt <= '0;
                            if (!line_s) begin
                                state    <= RX_BITS;
                                bit_idx  <= '0;
                                pay      <= '0;
                                xb_l     <= xb_en;
                                par_l    <= par_en;
                                last_idx <= IDX_W'(DATA_W - 1) + IDX_W'(xb_en) + IDX_W'(par_en);
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (tick_cnt == CNT_W'(OSR - 1)) begin
                            tick_cnt <= '0;
                            pay      <= pay | (PAY_W'(line_s) << bit_idx);
                            if (bit_idx == last_idx) state <= RX_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tick_cnt == CNT_W'(OSR - 1)) begin
                            tick_cnt         <= '0;
                            state            <= RX_IDLE;
                            frame_done       <= 1'b1;
                            frame_q.data     <= pay[DATA_W-1:0];
                            frame_q.xbit     <= xb_l ? pay[DATA_W] : 1'b0;
                            frame_q.par_bit  <= xb_l ? pay[DATA_W+1] : pay[DATA_W];
                            frame_q.xb_used  <= xb_l;
                            frame_q.par_used <= par_l;
                            frame_q.stop_ok  <= line_s;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/xbr_frame_eval.sv
// Combinational judgement of one finished frame: parity check, stop check
// and expansion-bit comparison.
// Assumes: the mode inputs are stable while frame_done is high.
module xbr_frame_eval
    import xbr_pkg::*;
(
    input  frame_t   frame,
    input  logic     cmp_disable,
    input  logic     data_cmp_enable,
    input  logic     detect_level,
    input  logic     parity_odd,
    output verdict_t verdict
);
    logic ones_odd;
    logic cmp_mode;

    // Work out the error and match outcome of the frame
    always_comb begin
        ones_odd        = ^frame.data ^ (frame.xb_used & frame.xbit) ^ frame.par_bit;
        cmp_mode        = frame.xb_used & ~cmp_disable & ~data_cmp_enable;
        verdict.par_err = frame.par_used & (ones_odd ^ parity_odd);
        verdict.frm_err = ~frame.stop_ok;
        verdict.match   = cmp_mode & (frame.xbit == detect_level);
    end
endmodule

// File: rtl/xbr_rx_status.sv
// Result registers: receive data, unread marker, sticky flags and the two
// single-cycle interrupt outputs.
// Assumes: rd_strobe does not coincide with frame_done.
module xbr_rx_status
    import xbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  verdict_t          verdict,
    input  logic              rd_strobe,
    input  logic [FLAG_W-1:0] clr_flags,
    output logic [DATA_W-1:0] rx_data,
    output logic [FLAG_W-1:0] status_flags,
    output logic              irq_status,
    output logic              irq_ok
);
    logic              unread;
    logic              ovr;
    logic              any_err;
    logic [FLAG_W-1:0] set_vec;

    // Decide the flags to set and the interrupt to route
    always_comb begin
        ovr             = frame_done & unread;
        any_err         = verdict.par_err | verdict.frm_err | ovr;
        set_vec         = '0;
        set_vec[FL_PAR] = frame_done & verdict.par_err;
        set_vec[FL_FRM] = frame_done & verdict.frm_err;
        set_vec[FL_OVR] = ovr;
        set_vec[FL_XDT] = frame_done & verdict.match
                          & (ovr | ~(verdict.par_err | verdict.frm_err));
    end

    // Store the byte and track whether it has been read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            unread  <= 1'b0;
        end else if (frame_done && !unread) begin
            rx_data <= frame_data;
            unread  <= 1'b1;
        end else if (rd_strobe) begin
            unread  <= 1'b0;
        end
    end

    // Sticky flags: set on events, cleared by write-one strobes
    always_ff @(posedge clk) begin
        if (!rst_n) status_flags <= '0;
        else        status_flags <= (status_flags & ~clr_flags) | set_vec;
    end

    // One interrupt pulse per frame, routed by error and match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_status <= 1'b0;
            irq_ok     <= 1'b0;
        end else begin
            irq_status <= frame_done & (any_err | verdict.match);
            irq_ok     <= frame_done & ~(any_err | verdict.match);
        end
    end
endmodule

// File: rtl/xbit_uart_rx.sv
// Top of the nine-bit UART receiver: front end, frame judgement and
// result registers.
// Assumes: mode inputs change only between frames.
module xbit_uart_rx
    import xbr_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              xb_enable,
    input  logic              cmp_disable,
    input  logic              data_cmp_enable,
    input  logic              detect_level,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              rd_strobe,
    input  logic [FLAG_W-1:0] clr_flags,
    output logic [DATA_W-1:0] rx_data,
    output logic [FLAG_W-1:0] status_flags,
    output logic              irq_status,
    output logic              irq_ok
);
    logic     frame_done;
    frame_t   frame;
    verdict_t verdict;

    xbr_bit_engine #(
        .OSR         (OSR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .baud_tick  (baud_tick),
        .xb_en      (xb_enable),
        .par_en     (parity_en),
        .frame_done (frame_done),
        .frame_q    (frame)
    );

    xbr_frame_eval u_eval (
        .frame           (frame),
        .cmp_disable     (cmp_disable),
        .data_cmp_enable (data_cmp_enable),
        .detect_level    (detect_level),
        .parity_odd      (parity_odd),
        .verdict         (verdict)
    );

    xbr_rx_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (frame_done),
        .frame_data   (frame.data),
        .verdict      (verdict),
        .rd_strobe    (rd_strobe),
        .clr_flags    (clr_flags),
        .rx_data      (rx_data),
        .status_flags (status_flags),
        .irq_status   (irq_status),
        .irq_ok       (irq_ok)
    );
endmodule

// File: rtl/xbr_rx_checker.sv
// Port-level properties of the nine-bit UART receiver, bound to its top.
// Assumes: frames are many cycles apart (at least one bit period).
module xbr_rx_checker
    import xbr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FLAG_W-1:0] clr_flags,
    input logic [DATA_W-1:0] rx_data,
    input logic [FLAG_W-1:0] status_flags,
    input logic              irq_status,
    input logic              irq_ok
);
    // R5: never both interrupts at once
    a_r5_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_status && irq_ok));

    // R5: interrupts are single-cycle pulses
    a_r5_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status |=> !irq_status);
    a_r5_ok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ok |=> !irq_ok);

    // R6: the data register changes only together with an interrupt
    a_r6_data_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> (irq_status || irq_ok));

    // R3: a newly set detect flag comes with the status interrupt
    a_r3_detect_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_flags[FL_XDT]) |-> irq_status);

    // R7: a newly set error flag never comes with the success interrupt
    a_r7_error_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flags[2:0] & ~$past(status_flags[2:0])) != 3'b000) |-> irq_status);

    // R10: a flag stays set until its clear strobe
    for (genvar i = 0; i < FLAG_W; i++) begin : g_sticky
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status_flags[i] && !clr_flags[i]) |=> status_flags[i]);
    end
endmodule

bind xbit_uart_rx xbr_rx_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_flags    (clr_flags),
    .rx_data      (rx_data),
    .status_flags (status_flags),
    .irq_status   (irq_status),
    .irq_ok       (irq_ok)
);

// File: tb/xbit_uart_rx_bench.sv
module xbit_uart_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_line, baud_tick;
    logic       xb_enable, cmp_disable, data_cmp_enable, detect_level;
    logic       parity_en, parity_odd, rd_strobe;
    logic [3:0] clr_flags;
    logic [7:0] rx_data;
    logic [3:0] status_flags;
    logic       irq_status, irq_ok;

    int n_checks = 0;
    int n_fail   = 0;
    int st_cnt   = 0;
    int ok_cnt   = 0;
    bit finished = 0;

    // model state
    bit       m_unread;
    bit [7:0] m_data;
    bit [3:0] m_flags;

    always #5 clk = ~clk;

    xbit_uart_rx u_xbit_uart_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .xb_enable(xb_enable), .cmp_disable(cmp_disable),
        .data_cmp_enable(data_cmp_enable), .detect_level(detect_level),
        .parity_en(parity_en), .parity_odd(parity_odd), .rd_strobe(rd_strobe),
        .clr_flags(clr_flags), .rx_data(rx_data), .status_flags(status_flags),
        .irq_status(irq_status), .irq_ok(irq_ok)
    );

    // count interrupt pulses away from the active edge
    always @(negedge clk) begin
        if (irq_status) st_cnt++;
        if (irq_ok)     ok_cnt++;
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        idle(16);
    endtask

    function automatic bit par_bit_of(input bit [7:0] d, input bit xb, input bit use_xb,
                                      input bit odd);
        bit ones = ^d ^ (use_xb & xb);
        return odd ? ~ones : ones;
    endfunction

    task automatic read_byte();
        rd_strobe = 1'b1; idle(1); rd_strobe = 1'b0;
        m_unread = 0;
    endtask

    task automatic clear(input bit [3:0] c);
        clr_flags = c; idle(1); clr_flags = '0;
        m_flags &= ~c;
    endtask

    // send one frame, update the model and compare the result
    task automatic send_and_check(input bit [7:0] d, input bit xb, input bit bad_par,
                                  input bit bad_stop, input string tag_hint);
        int st0, ok0;
        bit pb, cmp_mode, match, pe, fe, ov, to_st;
        string tag;
        pb = par_bit_of(d, xb, xb_enable, parity_odd) ^ bad_par;
        st0 = st_cnt; ok0 = ok_cnt;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (xb_enable) drive_bit(xb);
        if (parity_en) drive_bit(pb);
        drive_bit(~bad_stop);
        rx_line = 1'b1;
        idle(24);
        cmp_mode = xb_enable && !cmp_disable && !data_cmp_enable;
        match = cmp_mode && (xb == detect_level);
        pe = parity_en && bad_par;
        fe = bad_stop;
        ov = m_unread;
        if (!ov) begin m_data = d; m_unread = 1; end
        m_flags[0] |= pe;
        m_flags[1] |= fe;
        m_flags[2] |= ov;
        m_flags[3] |= match && (ov || !(pe || fe));
        to_st = pe || fe || ov || match;
        if (tag_hint != "") tag = tag_hint;
        else if (pe) tag = "R7";
        else if (fe) tag = "R8";
        else if (ov) tag = match ? "R9" : "R6";
        else if (match) tag = "R3";
        else if (cmp_mode) tag = "R4";
        else tag = "R1";
        chk(tag, "status irq count", st_cnt - st0, int'(to_st));
        chk(tag, "ok irq count", ok_cnt - ok0, int'(!to_st));
        chk("R5", "one irq per frame", (st_cnt - st0) + (ok_cnt - ok0), 1);
        chk(ov ? "R6" : "R2", "rx_data", rx_data, m_data);
        chk(tag == "R9" ? "R9" : "R10", "flags", status_flags, m_flags);
    endtask

    task automatic set_mode(input bit xe, input bit cd, input bit dce, input bit lvl,
                            input bit pen, input bit podd);
        xb_enable = xe; cmp_disable = cd; data_cmp_enable = dce;
        detect_level = lvl; parity_en = pen; parity_odd = podd;
    endtask

    // watchdog
    initial begin
        #1_900_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int st0, ok0;
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; rx_line = 1'b1; baud_tick = 1'b1;
        rd_strobe = 1'b0; clr_flags = '0;
        set_mode(0, 0, 0, 0, 0, 0);
        m_unread = 0; m_data = '0; m_flags = '0;
        idle(4);
        rst_n = 1'b1;
        idle(10);
        // R11: reset state
        chk("R11", "flags after reset", status_flags, 0);
        chk("R11", "rx_data after reset", rx_data, 0);
        chk("R11", "irq pulses after reset", st_cnt + ok_cnt, 0);

        // R2: plain 8-bit frame, LSB first
        send_and_check(8'hA5, 0, 0, 0, "R2");
        read_byte();

        // R12: short glitch is ignored
        st0 = st_cnt; ok0 = ok_cnt;
        rx_line = 1'b0; idle(4); rx_line = 1'b1; idle(40);
        chk("R12", "irq after glitch", (st_cnt - st0) + (ok_cnt - ok0), 0);
        chk("R12", "rx_data after glitch", rx_data, m_data);
        chk("R12", "flags after glitch", status_flags, m_flags);

        // R3 / R4: comparison with level 0
        set_mode(1, 0, 0, 0, 0, 0);
        send_and_check(8'h3C, 0, 0, 0, "R3");
        read_byte();
        send_and_check(8'hC3, 1, 0, 0, "R4");
        read_byte();
        clear(4'hF);

        // R1: comparison switched off in each way
        set_mode(1, 1, 0, 0, 0, 0);
        send_and_check(8'h11, 0, 0, 0, "R1");
        read_byte();
        set_mode(1, 0, 1, 0, 0, 0);
        send_and_check(8'h22, 0, 0, 0, "R1");
        read_byte();

        // R9: overrun on a matching frame sets detect too
        set_mode(1, 0, 0, 1, 0, 0);
        send_and_check(8'h44, 0, 0, 0, "R4");
        send_and_check(8'h55, 1, 0, 0, "R9");
        read_byte();
        clear(4'hF);
        // R9: parity error on a matching frame does not set detect
        set_mode(1, 0, 0, 1, 1, 1);
        send_and_check(8'h66, 1, 1, 0, "R9");
        read_byte();
        clear(4'hF);

        // R7 / R8 directed
        set_mode(0, 0, 0, 0, 1, 0);
        send_and_check(8'h81, 0, 1, 0, "R7");
        read_byte();
        send_and_check(8'h7E, 0, 0, 1, "R8");
        read_byte();
        clear(4'b0001);
        chk("R10", "single clear", status_flags, m_flags);
        clear(4'hF);

        // random mix
        for (int n = 0; n < 180; n++) begin
            bit [7:0] d;
            set_mode(($urandom % 5) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                     $urandom % 2, $urandom % 2, $urandom % 2);
            d = 8'($urandom);
            if (($urandom % 10) < 7) read_byte();
            if (($urandom % 4) == 0) clear(4'($urandom));
            send_and_check(d, $urandom % 2, ($urandom % 7) == 0, ($urandom % 10) == 0, "");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule